// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block decides, for a small 32-bit soft processor, whether a trap is taken in the current cycle and what the processor state looks like once it is. Five causes compete: a translation fault from the memory management unit, a hardware exception, a hardware break, a software break and an external interrupt request. The block picks one by fixed priority. One clock later it presents a one-cycle commit: the new program counter, a single link-register write (register index and value), the new machine status word, and two pulses that tell the pipeline to drop its prefix/delay-slot flags and its load reservation.

The block keeps three registers of its own: the exception syndrome, the fault address and the saved branch target. When a fault hits an instruction in a branch delay slot, the syndrome records that fact, and the saved branch target lets the handler resume the branch. For translation faults the link value is rewound so that the interrupted branch, and any immediate prefix in front of it, runs again after the handler returns. A combinational output tells the core whether an interrupt could be accepted right now. A translation fault that arrives before the previous one has been retired is not handled as a new trap; it latches a sticky double-fault flag instead.

The top-level reset is asynchronous and active low. The surrounding logic synchronises its release.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Causes are served in this priority order: translation fault, hardware exception, hardware break, software break, interrupt. Exactly one cause is committed per entry, one cycle after the cause is presented.
- R2: The new PC is VEC_BASE+0x10 for an interrupt and VEC_BASE+0x18 for a hardware break. It is VEC_BASE+0x20 for a hardware exception and for a translation fault. A software break jumps to btarget_i.
- R3: The link write goes to register 17 with PC+4 for a hardware exception, register 17 with the rewound PC for a translation fault, register 14 with PC for an interrupt, and register 16 with PC for a hardware break. A software break writes no link register.
- R4: For a translation fault, the link value is PC-4 when ds_i is set, or PC-8 when ds_i and bimm_i are both set. With ds_i clear, it is PC-4 when imm_i is set and PC otherwise.
- R5: On every entry, status bit 12 (UM shadow) takes the old bit 11 (UM) and bit 14 (VM shadow) takes the old bit 13 (VM). Bits 11 and 13 are then cleared. All other bits not named in R6 pass through unchanged.
- R6: An interrupt clears bit 1 (IE). A hardware exception or translation fault sets bit 9 (exception in progress). Either break sets bit 3 (break in progress).
- R7: A hardware exception or translation fault sets syndrome bit 12 to ds_i. When ds_i is set, btarget_i is also stored in the branch-target register. Otherwise that register keeps its value.
- R8: A translation fault writes a syndrome code into bits 4:0: 16 for a protection fault (mmu_miss_i=0) or 18 for a miss (mmu_miss_i=1), plus 1 when mmu_acc_i=2 (fetch). Bit 10 is set when mmu_acc_i=1 (store), where mmu_acc_i=0 means load. The fault address register takes mmu_addr_i.
- R9: irq_ok_o is high exactly when status bit 1 is set, bits 9 and 3 are clear, and neither ds_i nor imm_i is set. An interrupt is taken only when irq_ok_o is high.
- R10: With EXC_EN=0, a hardware exception is ignored. It causes no commit and no change to the syndrome or branch-target registers, and lower-priority causes are served as if it were absent.
- R11: flags_clr_o pulses with a hardware-exception or translation-fault entry. resv_clr_o pulses with every entry.
- R12: A translation fault that arrives while an earlier one is still unretired (no mmu_retire_i since it was taken) sets dfault_o. That cycle produces no commit and no register update. dfault_o then stays high until reset.
- R13: After reset, commit_o, link_we_o, flags_clr_o, resv_clr_o and dfault_o are low, and the syndrome, fault-address and branch-target registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | XLEN | PC of the instruction being trapped |
| btarget_i | input | XLEN | Pending branch target |
| ds_i | input | 1 | Instruction sits in a branch delay slot |
| imm_i | input | 1 | Immediate prefix active |
| bimm_i | input | 1 | The pending branch was immediate-prefixed |
| msr_i | input | XLEN | Current machine status word |
| irq_i | input | 1 | External interrupt request |
| hwexc_i | input | 1 | Hardware exception raised |
| hwbrk_i | input | 1 | Hardware break event |
| swbrk_i | input | 1 | Software break event |
| mmu_fault_i | input | 1 | Translation fault reported |
| mmu_miss_i | input | 1 | Fault kind: 1 miss, 0 protection |
| mmu_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| mmu_addr_i | input | XLEN | Faulting address |
| mmu_retire_i | input | 1 | Handler has retired the outstanding translation fault |
| irq_ok_o | output | 1 | An interrupt may be accepted now |
| commit_o | output | 1 | Entry commit pulse; pc_o and msr_o are valid |
| pc_o | output | XLEN | New program counter |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_o | output | XLEN | Link register value |
| msr_o | output | XLEN | New machine status word |
| flags_clr_o | output | 1 | Clear delay-slot and prefix flags |
| resv_clr_o | output | 1 | Clear load reservation |
| esr_o | output | XLEN | Syndrome register |
| ear_o | output | XLEN | Fault address register |
| btr_o | output | XLEN | Saved branch-target register |
| dfault_o | output | 1 | Sticky double-fault flag |

## Verification
The bench builds two instances with VEC_BASE=0x100: one with EXC_EN=1 and one with EXC_EN=0. A sweep covers every combination of the five cause inputs, the three pipeline flags and the five status bits that matter (IE, exception/break in progress, UM, VM). Fault kind and access type rotate across the vectors, so every priority conflict, every link rewind and every syndrome code is reached. The EXC_EN=0 instance makes the ignored-exception path visible. Directed sequences without a retire then exercise the double fault and its stickiness.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // status word bit positions
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;
  // syndrome bit positions
  localparam int ESR_ST  = 10;
  localparam int ESR_DS  = 12;
  // link register indices
  localparam logic [4:0] LINK_IRQ = 5'd14;
  localparam logic [4:0] LINK_BRK = 5'd16;
  localparam logic [4:0] LINK_EXC = 5'd17;
  // vector offsets
  localparam int VOFF_IRQ = 'h10;
  localparam int VOFF_BRK = 'h18;
  localparam int VOFF_EXC = 'h20;

  typedef enum logic [2:0] {
    C_NONE, C_MMU, C_HWEXC, C_HWBRK, C_SWBRK, C_IRQ
  } cause_e;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter bit EXC_EN = 1'b1
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic            ds_i,
  input  logic            imm_i,
  input  logic            irq_i,
  input  logic            hwexc_i,
  input  logic            hwbrk_i,
  input  logic            swbrk_i,
  input  logic            mmu_fault_i,
  input  logic            mmu_pend_i,
  output cause_e          cause_o,
  output logic            irq_ok_o,
  output logic            dfault_o
);
  always_comb begin
    irq_ok_o = msr_i[MSR_IE] & ~msr_i[MSR_EIP] & ~msr_i[MSR_BIP] & ~ds_i & ~imm_i;
    dfault_o = 1'b0;
    cause_o  = C_NONE;
    if (mmu_fault_i && mmu_pend_i)  dfault_o = 1'b1;
    else if (mmu_fault_i)           cause_o  = C_MMU;
    else if (hwexc_i && EXC_EN)     cause_o  = C_HWEXC;
    else if (hwbrk_i)               cause_o  = C_HWBRK;
    else if (swbrk_i)               cause_o  = C_SWBRK;
    else if (irq_i && irq_ok_o)     cause_o  = C_IRQ;
  end
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cause_e          cause_i,
  input  logic            ds_i,
  input  logic            miss_i,
  input  logic [1:0]      acc_i,
  input  logic [XLEN-1:0] esr_q_i,
  output logic [XLEN-1:0] esr_d_o,
  output logic            esr_en_o
);
  logic [4:0] code;

  always_comb begin
    code     = 5'd16 + (miss_i ? 5'd2 : 5'd0) + ((acc_i == ACC_FETCH) ? 5'd1 : 5'd0);
    esr_d_o  = esr_q_i;
    esr_en_o = 1'b0;
    if (cause_i == C_MMU) begin
      esr_en_o        = 1'b1;
      esr_d_o         = '0;
      esr_d_o[4:0]    = code;
      esr_d_o[ESR_ST] = (acc_i == ACC_STORE);
      esr_d_o[ESR_DS] = ds_i;
    end else if (cause_i == C_HWEXC) begin
      esr_en_o        = 1'b1;
      esr_d_o[ESR_DS] = ds_i;
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  cause_e          cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] btarget_i,
  input  logic            ds_i,
  input  logic            imm_i,
  input  logic            bimm_i,
  output logic [XLEN-1:0] pc_d_o,
  output logic            link_we_d_o,
  output logic [4:0]      link_idx_d_o,
  output logic [XLEN-1:0] link_d_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  logic [XLEN-1:0] rewind;

  always_comb begin
    if (ds_i)       rewind = bimm_i ? (STEP + STEP) : STEP;
    else if (imm_i) rewind = STEP;
    else            rewind = '0;

    pc_d_o       = pc_i;
    link_we_d_o  = 1'b0;
    link_idx_d_o = 5'd0;
    link_d_o     = '0;
    unique case (cause_i)
      C_MMU: begin
        pc_d_o = VEC_BASE + XLEN'(VOFF_EXC);
        link_we_d_o = 1'b1; link_idx_d_o = LINK_EXC; link_d_o = pc_i - rewind;
      end
      C_HWEXC: begin
        pc_d_o = VEC_BASE + XLEN'(VOFF_EXC);
        link_we_d_o = 1'b1; link_idx_d_o = LINK_EXC; link_d_o = pc_i + STEP;
      end
      C_HWBRK: begin
        pc_d_o = VEC_BASE + XLEN'(VOFF_BRK);
        link_we_d_o = 1'b1; link_idx_d_o = LINK_BRK; link_d_o = pc_i;
      end
      C_SWBRK: pc_d_o = btarget_i;
      C_IRQ: begin
        pc_d_o = VEC_BASE + XLEN'(VOFF_IRQ);
        link_we_d_o = 1'b1; link_idx_d_o = LINK_IRQ; link_d_o = pc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0,
  parameter bit              EXC_EN   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] btarget_i,
  input  logic            ds_i,
  input  logic            imm_i,
  input  logic            bimm_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic            irq_i,
  input  logic            hwexc_i,
  input  logic            hwbrk_i,
  input  logic            swbrk_i,
  input  logic            mmu_fault_i,
  input  logic            mmu_miss_i,
  input  logic [1:0]      mmu_acc_i,
  input  logic [XLEN-1:0] mmu_addr_i,
  input  logic            mmu_retire_i,
  output logic            irq_ok_o,
  output logic            commit_o,
  output logic [XLEN-1:0] pc_o,
  output logic            link_we_o,
  output logic [4:0]      link_idx_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] msr_o,
  output logic            flags_clr_o,
  output logic            resv_clr_o,
  output logic [XLEN-1:0] esr_o,
  output logic [XLEN-1:0] ear_o,
  output logic [XLEN-1:0] btr_o,
  output logic            dfault_o
);
  cause_e          cause;
  logic            take, dfault_now, exc_kind;
  logic            esr_en, ear_en, btr_en;
  logic [XLEN-1:0] esr_d, pc_d, link_d, msr_d;
  logic            link_we_d;
  logic [4:0]      link_idx_d;
  logic            pend_d, dfault_d;

  logic            commit_q, link_we_q, flags_clr_q, resv_clr_q, pend_q, dfault_q;
  logic [XLEN-1:0] pc_q, link_q, msr_q, esr_q, ear_q, btr_q;
  logic [4:0]      link_idx_q;

  exc_cause_arb #(.XLEN(XLEN), .EXC_EN(EXC_EN)) u_arb (
    .msr_i(msr_i), .ds_i(ds_i), .imm_i(imm_i), .irq_i(irq_i),
    .hwexc_i(hwexc_i), .hwbrk_i(hwbrk_i), .swbrk_i(swbrk_i),
    .mmu_fault_i(mmu_fault_i), .mmu_pend_i(pend_q),
    .cause_o(cause), .irq_ok_o(irq_ok_o), .dfault_o(dfault_now)
  );

  exc_syndrome #(.XLEN(XLEN)) u_syn (
    .cause_i(cause), .ds_i(ds_i), .miss_i(mmu_miss_i), .acc_i(mmu_acc_i),
    .esr_q_i(esr_q), .esr_d_o(esr_d), .esr_en_o(esr_en)
  );

  exc_target #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_tgt (
    .cause_i(cause), .pc_i(pc_i), .btarget_i(btarget_i),
    .ds_i(ds_i), .imm_i(imm_i), .bimm_i(bimm_i),
    .pc_d_o(pc_d), .link_we_d_o(link_we_d), .link_idx_d_o(link_idx_d),
    .link_d_o(link_d)
  );

  // next-state logic
  always_comb begin
    take     = (cause != C_NONE);
    exc_kind = (cause == C_MMU) || (cause == C_HWEXC);
    ear_en   = (cause == C_MMU);
    btr_en   = exc_kind && ds_i;

    msr_d          = msr_i;
    msr_d[MSR_UMS] = msr_i[MSR_UM];
    msr_d[MSR_VMS] = msr_i[MSR_VM];
    msr_d[MSR_UM]  = 1'b0;
    msr_d[MSR_VM]  = 1'b0;
    if (cause == C_IRQ)                          msr_d[MSR_IE]  = 1'b0;
    if (exc_kind)                                msr_d[MSR_EIP] = 1'b1;
    if (cause == C_HWBRK || cause == C_SWBRK)    msr_d[MSR_BIP] = 1'b1;

    if (cause == C_MMU)     pend_d = 1'b1;
    else if (mmu_retire_i)  pend_d = 1'b0;
    else                    pend_d = pend_q;
    dfault_d = dfault_q | dfault_now;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0; link_we_q <= 1'b0; flags_clr_q <= 1'b0; resv_clr_q <= 1'b0;
      pend_q <= 1'b0; dfault_q <= 1'b0;
      pc_q <= '0; link_q <= '0; link_idx_q <= '0; msr_q <= '0;
      esr_q <= '0; ear_q <= '0; btr_q <= '0;
    end else begin
      commit_q    <= take;
      link_we_q   <= link_we_d;
      flags_clr_q <= exc_kind;
      resv_clr_q  <= take;
      pend_q      <= pend_d;
      dfault_q    <= dfault_d;
      if (take) begin
        pc_q       <= pc_d;
        link_q     <= link_d;
        link_idx_q <= link_idx_d;
        msr_q      <= msr_d;
      end
      if (esr_en) esr_q <= esr_d;
      if (ear_en) ear_q <= mmu_addr_i;
      if (btr_en) btr_q <= btarget_i;
    end
  end

  assign commit_o    = commit_q;
  assign pc_o        = pc_q;
  assign link_we_o   = link_we_q;
  assign link_idx_o  = link_idx_q;
  assign link_o      = link_q;
  assign msr_o       = msr_q;
  assign flags_clr_o = flags_clr_q;
  assign resv_clr_o  = resv_clr_q;
  assign esr_o       = esr_q;
  assign ear_o       = ear_q;
  assign btr_o       = btr_q;
  assign dfault_o    = dfault_q;

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we_o && link_idx_o == LINK_IRQ) |-> $past(irq_ok_o));

  assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (msr_o[MSR_UMS] == $past(msr_i[MSR_UM]) && msr_o[MSR_VMS] == $past(msr_i[MSR_VM])
                  && !msr_o[MSR_UM] && !msr_o[MSR_VM]));

  assert_exc_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && link_we_o && link_idx_o == LINK_EXC) |-> (pc_o == VEC_BASE + XLEN'(VOFF_EXC)));

  assert_exc_eip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we_o && link_idx_o == LINK_EXC) |-> (msr_o[MSR_EIP] && flags_clr_o));

  assert_dfault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dfault_o |=> dfault_o);

  assert_dfault_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dfault_o) |-> (!commit_o && $stable(ear_o) && $stable(esr_o)));
endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  localparam logic [31:0] VB = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc, bt, msr, addr;
  logic ds, imm, bimm, irq, hwexc, hwbrk, swbrk, mf, miss, retire;
  logic [1:0] acc;

  logic irq_ok, commit, link_we, fclr, rclr, dfault;
  logic [31:0] npc, link, nmsr, esr, ear, btr;
  logic [4:0] lidx;
  logic n_irq_ok, n_commit, n_link_we, n_fclr, n_rclr, n_dfault;
  logic [31:0] n_npc, n_link, n_nmsr, n_esr, n_ear, n_btr;
  logic [4:0] n_lidx;

  exc_entry_ctrl #(.XLEN(32), .VEC_BASE(VB), .EXC_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .btarget_i(bt), .ds_i(ds), .imm_i(imm),
    .bimm_i(bimm), .msr_i(msr), .irq_i(irq), .hwexc_i(hwexc), .hwbrk_i(hwbrk),
    .swbrk_i(swbrk), .mmu_fault_i(mf), .mmu_miss_i(miss), .mmu_acc_i(acc),
    .mmu_addr_i(addr), .mmu_retire_i(retire), .irq_ok_o(irq_ok), .commit_o(commit),
    .pc_o(npc), .link_we_o(link_we), .link_idx_o(lidx), .link_o(link), .msr_o(nmsr),
    .flags_clr_o(fclr), .resv_clr_o(rclr), .esr_o(esr), .ear_o(ear), .btr_o(btr),
    .dfault_o(dfault));

  exc_entry_ctrl #(.XLEN(32), .VEC_BASE(VB), .EXC_EN(1'b0)) u_dut_noexc (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .btarget_i(bt), .ds_i(ds), .imm_i(imm),
    .bimm_i(bimm), .msr_i(msr), .irq_i(irq), .hwexc_i(hwexc), .hwbrk_i(hwbrk),
    .swbrk_i(swbrk), .mmu_fault_i(mf), .mmu_miss_i(miss), .mmu_acc_i(acc),
    .mmu_addr_i(addr), .mmu_retire_i(retire), .irq_ok_o(n_irq_ok), .commit_o(n_commit),
    .pc_o(n_npc), .link_we_o(n_link_we), .link_idx_o(n_lidx), .link_o(n_link), .msr_o(n_nmsr),
    .flags_clr_o(n_fclr), .resv_clr_o(n_rclr), .esr_o(n_esr), .ear_o(n_ear), .btr_o(n_btr),
    .dfault_o(n_dfault));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] m_esr = '0, m_ear = '0, m_btr = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input logic ret);
    irq = 0; hwexc = 0; hwbrk = 0; swbrk = 0; mf = 0; retire = ret;
    ds = 0; imm = 0; bimm = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pc = 0; bt = 0; msr = 0; addr = 0; miss = 0; acc = 0;
    idle(1'b0);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 commit", {31'd0, commit}, 0);
    chk("R13 link_we", {31'd0, link_we}, 0);
    chk("R13 flags/resv", {30'd0, fclr, rclr}, 0);
    chk("R13 dfault", {31'd0, dfault}, 0);
    chk("R13 esr", esr, 0);
    chk("R13 ear", ear, 0);
    chk("R13 btr", btr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 8; f++) begin
        for (int m = 0; m < 32; m++) begin
          automatic int n = c * 256 + f * 32 + m;
          automatic logic ok;
          automatic int cs;  // 0 none 1 mmu 2 hwexc 3 hwbrk 4 swbrk 5 irq
          automatic logic [31:0] e_pc, e_link, e_msr, rw;
          automatic logic [4:0] e_idx;
          automatic logic e_we;
          mf = c[0]; hwexc = c[1]; hwbrk = c[2]; swbrk = c[3]; irq = c[4];
          ds = f[0]; imm = f[1]; bimm = f[2];
          msr = 32'h8000_0001;
          msr[1] = m[0]; msr[9] = m[1]; msr[3] = m[2]; msr[11] = m[3]; msr[13] = m[4];
          miss = n[0]; acc = 2'((n >> 1) % 3);
          pc = 32'h2000_0000 + 32'(n) * 16;
          bt = 32'h3000_0004 + 32'(n) * 8;
          addr = 32'h4000_0000 ^ (32'(n) << 2);
          retire = 0;
          #1;
          ok = msr[1] & ~msr[9] & ~msr[3] & ~ds & ~imm;
          chk("R9 irq_ok", {31'd0, irq_ok}, {31'd0, ok});
          if (mf) cs = 1; else if (hwexc) cs = 2; else if (hwbrk) cs = 3;
          else if (swbrk) cs = 4; else if (irq && ok) cs = 5; else cs = 0;
          rw = ds ? (bimm ? 8 : 4) : (imm ? 4 : 0);
          e_msr = msr;
          e_msr[12] = msr[11]; e_msr[14] = msr[13]; e_msr[11] = 0; e_msr[13] = 0;
          e_we = 1; e_pc = VB + 32'h20; e_idx = 17; e_link = pc;
          case (cs)
            1: begin e_link = pc - rw; e_msr[9] = 1;
                 m_esr = 32'(16 + (miss ? 2 : 0) + (acc == 2 ? 1 : 0));
                 m_esr[10] = (acc == 1); m_esr[12] = ds; m_ear = addr;
                 if (ds) m_btr = bt; end
            2: begin e_link = pc + 4; e_msr[9] = 1; m_esr[12] = ds;
                 if (ds) m_btr = bt; end
            3: begin e_pc = VB + 32'h18; e_idx = 16; e_msr[3] = 1; end
            4: begin e_pc = bt; e_we = 0; e_msr[3] = 1; end
            5: begin e_pc = VB + 32'h10; e_idx = 14; e_msr[1] = 0; end
            default: e_we = 0;
          endcase
          @(posedge clk); @(negedge clk);
          chk("R1 commit", {31'd0, commit}, {31'd0, cs != 0});
          chk("R3 link_we", {31'd0, link_we}, {31'd0, e_we});
          chk("R11 flags_clr", {31'd0, fclr}, {31'd0, cs == 1 || cs == 2});
          chk("R11 resv_clr", {31'd0, rclr}, {31'd0, cs != 0});
          if (cs != 0) begin
            chk("R2 pc", npc, e_pc);
            chk("R5 R6 msr", nmsr, e_msr);
          end
          if (e_we) begin
            chk("R3 link_idx", {27'd0, lidx}, {27'd0, e_idx});
            if (cs == 1) chk("R4 link rewind", link, e_link);
            else chk("R3 link", link, e_link);
          end
          chk("R7 R8 esr", esr, m_esr);
          chk("R8 ear", ear, m_ear);
          chk("R7 btr", btr, m_btr);
          chk("R12 no dfault", {31'd0, dfault}, 0);
          idle(1'b1);
          @(negedge clk);
        end
      end
    end

    // R10: exceptions disabled instance ignores hwexc
    begin
      automatic logic [31:0] e0 = n_esr, b0 = n_btr;
      idle(1'b1); hwexc = 1; ds = 1; bt = 32'hDEAD_0000; msr = 32'h2;
      @(posedge clk); @(negedge clk);
      chk("R10 no commit", {31'd0, n_commit}, 0);
      chk("R10 esr unchanged", n_esr, e0);
      chk("R10 btr unchanged", n_btr, b0);
      idle(1'b1); hwexc = 1; irq = 1; pc = 32'h5000_0000;
      @(posedge clk); @(negedge clk);
      chk("R10 irq served", {31'd0, n_commit}, 1);
      chk("R10 irq link idx", {27'd0, n_lidx}, 14);
      chk("R10 irq vector", n_npc, VB + 32'h10);
      idle(1'b1); @(negedge clk);
    end

    // R12: double fault
    begin
      idle(1'b0); mf = 1; addr = 32'h1111_2220; miss = 1; acc = 0; pc = 32'h6000_0000;
      @(posedge clk); @(negedge clk);
      chk("R12 first fault commit", {31'd0, commit}, 1);
      chk("R8 ear first", ear, 32'h1111_2220);
      chk("R8 esr miss load", esr & 32'h1F, 18);
      idle(1'b0); @(posedge clk); @(negedge clk);
      mf = 1; addr = 32'h3333_4440; miss = 0; acc = 1;
      @(posedge clk); @(negedge clk);
      chk("R12 dfault set", {31'd0, dfault}, 1);
      chk("R12 no commit", {31'd0, commit}, 0);
      chk("R12 ear kept", ear, 32'h1111_2220);
      idle(1'b1); hwexc = 1; pc = 32'h7000_0000;
      @(posedge clk); @(negedge clk);
      chk("R12 sticky", {31'd0, dfault}, 1);
      chk("R1 hwexc after dfault", {31'd0, commit}, 1);
      chk("R3 hwexc link", link, 32'h7000_0004);
      idle(1'b1); @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule